// File: doc/BRIEF.md
# PCI Memory and Configuration Target Controller

This block is the target-side transaction engine of a 32-bit PCI agent. On every rising clock edge it samples FRAME#, IRDY#, IDSEL, the multiplexed address/data bus and the command/byte-enable lines. It decides whether a new transaction addresses this agent: either a memory command inside its address window, or a configuration command with IDSEL high. When the transaction is for this agent, it runs a fixed claim sequence on DEVSEL# and TRDY#. It then moves each data phase to one of two local ports: a configuration-register port or a local memory port.

The base of the memory window and the memory-space enable come from a separate configuration register block. The target never signals STOP#. It lets a burst run until the initiator marks the last data phase, and then it drives its control lines high for one clock before it releases them. Tri-state control is brought out as separate output-enable signals, so the pad ring can build the bus drivers.

Top module: `pcitgt_ctrl`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and in the first clock after it, `ctl_oe_o`, `ad_oe_o` and all four data strobes are 0.
- R2: An address phase (FRAME# low, sampled in idle) with C/BE#[3:1] = 3'b011 claims a memory access only when `mem_en_i` is 1 and AD[31:WIN_BITS] equals `win_base_i`.
- R3: An address phase with C/BE#[3:1] = 3'b101 and IDSEL high claims a configuration access. The dword index sent to the configuration port is AD[7:2] of the address phase, and it stays fixed for the whole burst.
- R4: Any other address phase (wrong command, miss on the window, memory disabled, IDSEL low) is not claimed. `ctl_oe_o` stays 0 and no strobe fires until FRAME# and IRDY# have both been sampled high.
- R5: After a claimed address edge, the outputs follow a fixed sequence. The first clock is undriven. The second has DEVSEL# and TRDY# driven high. The third has DEVSEL# low and TRDY# high. From the fourth clock on, both are low.
- R6: A data phase (one strobe, selected by space and direction) happens only in a clock where TRDY# is low and IRDY# is sampled low. IRDY# high while TRDY# is low inserts a wait with no strobe.
- R7: During a claimed read, `ad_oe_o` is 1 from the DEVSEL#-low clock on. `ad_o` carries the data of the selected port at the current index.
- R8: In a memory burst, the dword index starts at AD[WIN_BITS-1:2] and steps by one (4 bytes) after every data phase, wrapping inside the window.
- R9: A data phase sampled with FRAME# high ends the burst. In the next clock DEVSEL#, TRDY# and STOP# are driven high, and one clock later all outputs are released.
- R10: If FRAME# and IRDY# are both sampled high before the first data clock, the target goes straight to the one-clock drive-high ending of R9.
- R11: C/BE#[0] of the address phase selects write (1) or read (0). Write strobes carry AD as data and the inverted C/BE# of the data phase as byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | FRAME# from the bus |
| irdy_n_i | input | 1 | IRDY# from the bus |
| idsel_i | input | 1 | IDSEL for configuration cycles |
| ad_i | input | 32 | Address/data bus as received |
| cbe_n_i | input | 4 | Command / byte enables, active low |
| win_base_i | input | 32-WIN_BITS | Upper address bits of the memory window |
| mem_en_i | input | 1 | Memory-space response enable |
| ad_o | output | 32 | Read data to drive onto AD |
| ad_oe_o | output | 1 | Enable for the AD drivers |
| devsel_n_o | output | 1 | DEVSEL# value |
| trdy_n_o | output | 1 | TRDY# value |
| stop_n_o | output | 1 | STOP# value |
| ctl_oe_o | output | 1 | Enable for DEVSEL#, TRDY#, STOP# drivers |
| cfg_idx_o | output | 6 | Configuration dword index |
| cfg_wr_o | output | 1 | Configuration write strobe |
| cfg_rd_o | output | 1 | Configuration read strobe |
| cfg_rdata_i | input | 32 | Configuration read data |
| mem_idx_o | output | WIN_BITS-2 | Local memory dword index |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 32 | Memory read data |
| wr_data_o | output | 32 | Write data for both ports |
| wr_be_o | output | 4 | Active-high byte enables for both ports |

## Verification
On every cycle, the assertions check the claim ordering (DEVSEL# falls only after a driven-high clock, TRDY# only after DEVSEL#). They also check the drive-high clock before release, that at most one strobe fires and only with both ready lines low, that a claim only follows a decoded hit, and how the index moves after each data phase. The bench scenarios are needed to show the rest. These include which address and command combinations are claimed or ignored, the exact cycle of each step of the claim sequence, the data and byte enables that reach the ports, and read-back of the data. They also cover wrap-around at the window edge and wait states from the initiator. Read-back after ignored writes shows that a miss never reached the memory.

// File: rtl/pcitgt_pkg.sv
package pcitgt_pkg;

    // Target response states; order matters only for readability
    typedef enum logic [2:0] {
        ST_IDLE,      // bus released, watching for an address phase
        ST_SKIP,      // transaction for someone else, wait for bus idle
        ST_READY,     // address latched, outputs still released
        ST_CLAIM_HI,  // DEVSEL# and TRDY# driven high
        ST_CLAIM,     // DEVSEL# low, TRDY# high
        ST_DATA,      // DEVSEL# and TRDY# low, data phases
        ST_DONE       // all controls driven high for one clock
    } tgt_state_e;

    localparam logic [2:0] CMD_MEM = 3'b011;
    localparam logic [2:0] CMD_CFG = 3'b101;

endpackage

// File: rtl/pcitgt_decode.sv
module pcitgt_decode
    import pcitgt_pkg::*;
#(
    parameter int BASE_W = 24
) (
    input  logic [BASE_W-1:0] ad_hi_i,
    input  logic [BASE_W-1:0] win_base_i,
    input  logic [2:0]        cmd_hi_i,
    input  logic              idsel_i,
    input  logic              mem_en_i,
    output logic              hit_o,
    output logic              is_cfg_o
);

    logic mem_hit;
    logic cfg_hit;

    always_comb begin
        mem_hit  = (cmd_hi_i == CMD_MEM) && mem_en_i && (ad_hi_i == win_base_i);
        cfg_hit  = (cmd_hi_i == CMD_CFG) && idsel_i;
        hit_o    = mem_hit || cfg_hit;
        is_cfg_o = cfg_hit;
    end

endmodule

// File: rtl/pcitgt_seq.sv
module pcitgt_seq
    import pcitgt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic frame_n_i,
    input  logic irdy_n_i,
    input  logic hit_i,
    output logic addr_phase_o,
    output logic beat_win_o,
    output logic data_win_o,
    output logic oe_o,
    output logic devsel_n_o,
    output logic trdy_n_o,
    output logic stop_n_o
);

    tgt_state_e state_d;
    tgt_state_e state_q;
    logic       bus_quiet;

    assign bus_quiet = frame_n_i && irdy_n_i;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (!frame_n_i) state_d = hit_i ? ST_READY : ST_SKIP;
            ST_SKIP:     if (bus_quiet) state_d = ST_IDLE;
            ST_READY:    state_d = bus_quiet ? ST_DONE : ST_CLAIM_HI;
            ST_CLAIM_HI: state_d = bus_quiet ? ST_DONE : ST_CLAIM;
            ST_CLAIM:    state_d = bus_quiet ? ST_DONE : ST_DATA;
            ST_DATA:     if (frame_n_i && (irdy_n_i || !trdy_n_o)) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        addr_phase_o = (state_q == ST_IDLE) && !frame_n_i;
        beat_win_o   = (state_q == ST_DATA);
        data_win_o   = (state_q == ST_CLAIM) || (state_q == ST_DATA);
        oe_o         = (state_q == ST_CLAIM_HI) || (state_q == ST_CLAIM) ||
                       (state_q == ST_DATA)     || (state_q == ST_DONE);
        devsel_n_o   = !data_win_o;
        trdy_n_o     = (state_q != ST_DATA);
        stop_n_o     = 1'b1;
    end

    AST_DEVSEL_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(devsel_n_o) |-> ($past(oe_o) && $past(trdy_n_o)));          // R5
    AST_TRDY_AFTER_DEVSEL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(trdy_n_o) |-> $past(!devsel_n_o));                          // R5
    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(oe_o) |-> $past(devsel_n_o && trdy_n_o && stop_n_o));       // R9

endmodule

// File: rtl/pcitgt_ctrl.sv
module pcitgt_ctrl
    import pcitgt_pkg::*;
#(
    parameter  int WIN_BITS = 8,
    localparam int BASE_W   = 32 - WIN_BITS,
    localparam int IDX_W    = WIN_BITS - 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              frame_n_i,
    input  logic              irdy_n_i,
    input  logic              idsel_i,
    input  logic [31:0]       ad_i,
    input  logic [3:0]        cbe_n_i,
    input  logic [BASE_W-1:0] win_base_i,
    input  logic              mem_en_i,
    output logic [31:0]       ad_o,
    output logic              ad_oe_o,
    output logic              devsel_n_o,
    output logic              trdy_n_o,
    output logic              stop_n_o,
    output logic              ctl_oe_o,
    output logic [5:0]        cfg_idx_o,
    output logic              cfg_wr_o,
    output logic              cfg_rd_o,
    input  logic [31:0]       cfg_rdata_i,
    output logic [IDX_W-1:0]  mem_idx_o,
    output logic              mem_wr_o,
    output logic              mem_rd_o,
    input  logic [31:0]       mem_rdata_i,
    output logic [31:0]       wr_data_o,
    output logic [3:0]        wr_be_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             is_cfg;
        logic             is_wr;
        logic             hit;
    } txn_t;

    txn_t txn_d;
    txn_t txn_q;
    logic dec_hit;
    logic dec_cfg;
    logic addr_phase;
    logic beat_win;
    logic data_win;
    logic beat;

    pcitgt_decode #(.BASE_W(BASE_W)) u_decode (
        .ad_hi_i    (ad_i[31:WIN_BITS]),
        .win_base_i (win_base_i),
        .cmd_hi_i   (cbe_n_i[3:1]),
        .idsel_i    (idsel_i),
        .mem_en_i   (mem_en_i),
        .hit_o      (dec_hit),
        .is_cfg_o   (dec_cfg)
    );

    pcitgt_seq u_seq (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .frame_n_i    (frame_n_i),
        .irdy_n_i     (irdy_n_i),
        .hit_i        (dec_hit),
        .addr_phase_o (addr_phase),
        .beat_win_o   (beat_win),
        .data_win_o   (data_win),
        .oe_o         (ctl_oe_o),
        .devsel_n_o   (devsel_n_o),
        .trdy_n_o     (trdy_n_o),
        .stop_n_o     (stop_n_o)
    );

    assign beat = beat_win && !irdy_n_i;

    always_comb begin
        txn_d = txn_q;
        if (addr_phase) begin
            txn_d.idx    = ad_i[WIN_BITS-1:2];
            txn_d.is_cfg = dec_cfg;
            txn_d.is_wr  = cbe_n_i[0];
            txn_d.hit    = dec_hit;
        end else if (beat && !txn_q.is_cfg) begin
            txn_d.idx = txn_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) txn_q <= '0;
        else          txn_q <= txn_d;
    end

    always_comb begin
        cfg_idx_o = txn_q.idx[5:0];
        mem_idx_o = txn_q.idx;
        cfg_wr_o  = beat &&  txn_q.is_cfg &&  txn_q.is_wr;
        cfg_rd_o  = beat &&  txn_q.is_cfg && !txn_q.is_wr;
        mem_wr_o  = beat && !txn_q.is_cfg &&  txn_q.is_wr;
        mem_rd_o  = beat && !txn_q.is_cfg && !txn_q.is_wr;
        wr_data_o = ad_i;
        wr_be_o   = ~cbe_n_i;
        ad_o      = txn_q.is_cfg ? cfg_rdata_i : mem_rdata_i;
        ad_oe_o   = data_win && !txn_q.is_wr;
    end

    AST_CLAIM_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ctl_oe_o && !devsel_n_o) |-> txn_q.hit);                            // R4
    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({cfg_wr_o, cfg_rd_o, mem_wr_o, mem_rd_o}));                 // R6
    AST_STROBE_BOTH_READY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cfg_wr_o || cfg_rd_o || mem_wr_o || mem_rd_o) |-> (!irdy_n_i && !trdy_n_o)); // R6
    AST_MEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mem_wr_o || mem_rd_o) |=> (mem_idx_o == IDX_W'($past(mem_idx_o) + 1'b1)));  // R8
    AST_CFG_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cfg_wr_o || cfg_rd_o) |=> $stable(cfg_idx_o));                      // R3

endmodule

// File: tb/pcitgt_ctrl_tb_top.sv
module pcitgt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n, idsel, mem_en;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic [23:0] win_base;
    logic [31:0] ad_o, cfg_rdata, mem_rdata, wr_data;
    logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;
    logic [5:0]  cfg_idx, mem_idx;
    logic        cfg_wr, cfg_rd, mem_wr, mem_rd;
    logic [3:0]  wr_be;

    logic [31:0] dev_mem [0:63];
    logic [31:0] dev_cfg [0:63];
    logic [31:0] exp_mem [0:63];
    logic [31:0] exp_cfg [0:63];

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pcitgt_ctrl #(.WIN_BITS(8)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .idsel_i(idsel), .ad_i(ad), .cbe_n_i(cbe_n), .win_base_i(win_base),
        .mem_en_i(mem_en), .ad_o(ad_o), .ad_oe_o(ad_oe), .devsel_n_o(devsel_n),
        .trdy_n_o(trdy_n), .stop_n_o(stop_n), .ctl_oe_o(ctl_oe),
        .cfg_idx_o(cfg_idx), .cfg_wr_o(cfg_wr), .cfg_rd_o(cfg_rd), .cfg_rdata_i(cfg_rdata),
        .mem_idx_o(mem_idx), .mem_wr_o(mem_wr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
        .wr_data_o(wr_data), .wr_be_o(wr_be)
    );

    function automatic logic [31:0] merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                          input logic [3:0] be);
        logic [31:0] r = old_v;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        return r;
    endfunction

    // Local device models behind the two ports
    assign mem_rdata = dev_mem[mem_idx];
    assign cfg_rdata = dev_cfg[cfg_idx];
    always @(posedge clk) begin
        if (mem_wr) dev_mem[mem_idx] <= merge(dev_mem[mem_idx], wr_data, wr_be);
        if (cfg_wr) dev_cfg[cfg_idx] <= merge(dev_cfg[cfg_idx], wr_data, wr_be);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bus(input string req, input logic oe, input logic dv, input logic tr);
        check({req, " ctl_oe"}, {31'd0, ctl_oe}, {31'd0, oe});
        if (oe) check({req, " devsel/trdy/stop"}, {29'd0, devsel_n, trdy_n, stop_n},
                      {29'd0, dv, tr, 1'b1});
    endtask

    task automatic chk_quiet(input string req);
        check({req, " strobes"}, {28'd0, cfg_wr, cfg_rd, mem_wr, mem_rd}, 32'd0);
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a, input int k);
        return 32'h5A00_0000 ^ (a << 8) ^ (32'h0001_1111 * (k + 1));
    endfunction

    // Claimed transaction; expected values computed from R2..R11
    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input int n, input logic [3:0] be_n, input int wait_at);
        logic wr  = cmd[0];
        logic cfg = (cmd[3:1] == 3'b101);
        int   base_idx = int'(addr[7:2]);
        @(negedge clk);
        chk_bus("R1 idle before address", 1'b0, 1'b1, 1'b1);
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd; idsel = sel;
        @(negedge clk);
        chk_bus("R5 ready clock undriven", 1'b0, 1'b1, 1'b1);
        idsel = 1'b0; cbe_n = be_n; irdy_n = 1'b0; frame_n = (n == 1);
        ad = wr ? pat(addr, 0) : 32'h0;
        @(negedge clk);
        chk_bus("R5 driven high", 1'b1, 1'b1, 1'b1);
        chk_quiet("R6 no strobe before TRDY#");
        @(negedge clk);
        chk_bus("R5 devsel low trdy high", 1'b1, 1'b0, 1'b1);
        check("R7 ad_oe in claim", {31'd0, ad_oe}, {31'd0, !wr});
        chk_quiet("R6 no strobe in claim");
        for (int k = 0; k < n; k++) begin
            int idx = cfg ? base_idx : ((base_idx + k) % 64);
            logic [31:0] d = pat(addr, k);
            @(negedge clk);
            chk_bus("R5 data clock", 1'b1, 1'b0, 1'b0);
            if (k == wait_at) begin
                irdy_n = 1'b1; frame_n = 1'b0;
                #1 chk_quiet("R6 wait state");
                @(negedge clk);
                chk_bus("R6 after wait", 1'b1, 1'b0, 1'b0);
            end
            irdy_n = 1'b0; frame_n = (k == n - 1); ad = wr ? d : 32'h0; cbe_n = be_n;
            #1;
            check("R11 strobe kind", {28'd0, cfg_wr, cfg_rd, mem_wr, mem_rd},
                  {28'd0, cfg && wr, cfg && !wr, !cfg && wr, !cfg && !wr});
            if (cfg) check("R3 cfg index", {26'd0, cfg_idx}, idx);
            else     check("R8 mem index", {26'd0, mem_idx}, idx);
            if (wr) begin
                check("R11 write data", wr_data, d);
                check("R11 byte enables", {28'd0, wr_be}, {28'd0, ~be_n});
                if (cfg) exp_cfg[idx] = merge(exp_cfg[idx], d, ~be_n);
                else     exp_mem[idx] = merge(exp_mem[idx], d, ~be_n);
            end else begin
                check("R7 ad_oe", {31'd0, ad_oe}, 32'd1);
                check("R7 read data", ad_o, cfg ? exp_cfg[idx] : exp_mem[idx]);
            end
        end
        @(negedge clk);
        chk_bus("R9 drive-high clock", 1'b1, 1'b1, 1'b1);
        chk_quiet("R9 no strobe after last");
        frame_n = 1'b1; irdy_n = 1'b1; ad = 32'h0; cbe_n = 4'hF;
    endtask

    // Unclaimed transaction: nothing may be driven or strobed
    task automatic txn_miss(input logic [3:0] cmd, input logic [31:0] addr, input logic sel);
        @(negedge clk);
        chk_bus("R4 idle before miss", 1'b0, 1'b1, 1'b1);
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd; idsel = sel;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk_bus("R4 miss undriven", 1'b0, 1'b1, 1'b1);
            chk_quiet("R4 miss no strobe");
            idsel = 1'b0; irdy_n = 1'b0; frame_n = (k >= 3); cbe_n = 4'h0;
            ad = 32'hDEAD_0000 | k;
        end
        @(negedge clk);
        chk_bus("R4 miss still undriven", 1'b0, 1'b1, 1'b1);
        frame_n = 1'b1; irdy_n = 1'b1; ad = 32'h0; cbe_n = 4'hF;
        @(negedge clk);
        chk_bus("R4 back to idle", 1'b0, 1'b1, 1'b1);
    endtask

    // Claimed address followed by immediate bus idle
    task automatic txn_abort(input logic [3:0] cmd, input logic [31:0] addr);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
        @(negedge clk);
        chk_bus("R10 ready undriven", 1'b0, 1'b1, 1'b1);
        frame_n = 1'b1; irdy_n = 1'b1; ad = 32'h0; cbe_n = 4'hF;
        @(negedge clk);
        chk_bus("R10 drive-high ending", 1'b1, 1'b1, 1'b1);
        chk_quiet("R10 no strobe");
        @(negedge clk);
        chk_bus("R10 released", 1'b0, 1'b1, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = 32'h0101_0101 * i;  exp_mem[i] = 32'h0101_0101 * i;
            dev_cfg[i] = 32'hC000_0000 | i;  exp_cfg[i] = 32'hC000_0000 | i;
        end
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
        ad = 32'h0; cbe_n = 4'hF; win_base = 24'hCD0000; mem_en = 1'b1;
        repeat (3) @(negedge clk);
        chk_bus("R1 in reset", 1'b0, 1'b1, 1'b1);
        chk_quiet("R1 in reset");
        check("R1 ad_oe in reset", {31'd0, ad_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bus("R1 after reset", 1'b0, 1'b1, 1'b1);

        txn(4'b0111, 32'hCD00_0010, 1'b0, 4, 4'h0, -1);   // R2 memory write burst
        txn(4'b0110, 32'hCD00_0010, 1'b0, 4, 4'h0, -1);   // R2 R7 read back
        txn(4'b0111, 32'hCD00_00FC, 1'b0, 3, 4'b1100, 1); // R8 wrap, partial, wait
        txn(4'b0110, 32'hCD00_00FC, 1'b0, 3, 4'h0, 2);    // R8 read wrap with wait
        txn(4'b1011, 32'h0000_003C, 1'b1, 1, 4'h0, -1);   // R3 config write
        txn(4'b1010, 32'h0000_003C, 1'b1, 2, 4'h0, -1);   // R3 config read, index held
        txn_miss(4'b1011, 32'h0000_003C, 1'b0);           // R4 config without IDSEL
        txn_miss(4'b0111, 32'hCE00_0010, 1'b0);           // R4 outside window
        mem_en = 1'b0;
        txn_miss(4'b0111, 32'hCD00_0014, 1'b0);           // R4 memory disabled
        mem_en = 1'b1;
        txn_miss(4'b0011, 32'hCD00_0018, 1'b0);           // R4 unsupported command
        txn_abort(4'b0110, 32'hCD00_0020);                // R10
        txn(4'b0110, 32'hCD00_0010, 1'b0, 3, 4'h0, -1);   // R4 misses left memory untouched
        txn(4'b1010, 32'h0000_003C, 1'b1, 1, 4'h0, -1);   // R4 config untouched
        @(negedge clk);
        chk_bus("R9 released at end", 1'b0, 1'b1, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule